// File: doc/BRIEF.md
# Software-Raised Inter-Processor Interrupt Unit

This block lets code running on one core of a small multi-core cluster interrupt one or more of its peers, or itself. A core writes a single generate word. Two bits of that word pick how the targets are chosen: an explicit CPU list, every core except the writer, or the writer alone. The low bits name one of the software interrupt numbers. For each target, the unit records a pending flag for the pair formed by the interrupt number and the sending core.

Each core has its own acknowledge, end and active-clear ports. The acknowledge port always shows the best deliverable pair for that core, or a spurious code when nothing is deliverable. Pulsing the read strobe commits the read: the shown pair moves from pending to active. The core ends the interrupt in one of two ways. It can write the acknowledged word back on its end port. It can also write a bit mask on its active-clear port, which drops the active state of every marked interrupt number, whatever its source.

A pair that is active is never offered again until it has been ended. This holds even if a new request for the same pair arrives in the meantime. The new request stays pending and is delivered once, after the end.

Top module: `sgi_unit`

## Requirements
- R1: After reset no core has an interrupt request, and every acknowledge word reads 0x000003FF, the spurious code.
- R2: A deliverable acknowledge word carries the interrupt number in bits [9:0] and the sending core in bits [12:10]. All other bits are zero.
- R3: Filter value 0 in bits [25:24] targets the cores whose bits are set in bits [23:16]. List bits for cores beyond NCPU are ignored.
- R4: Filter value 1 targets every core except the writer (gen_cpu).
- R5: Filter value 2 targets only the writer.
- R6: Filter value 3 raises nothing on any core.
- R7: Pulsing the read strobe while the spurious code is shown changes no state. That core stays idle and later reads are unaffected.
- R8: A committed read moves the pair from pending to active. An active pair is not offered again, even when it is requested anew, until it is ended.
- R9: Among deliverable pairs, the lowest interrupt number wins. Equal numbers go to the lowest sending core.
- R10: Writing an acknowledged word back on the end port ends that pair for that core. A word that names a pair which is not active, or has nonzero bits above bit 12, ends nothing.
- R11: On the active-clear port, a set bit n ends interrupt number n from every source on that core.
- R12: When a new request for a pair and a committed read of that same pair fall in the same cycle, the read returns the pair and the new request stays pending. The new request is delivered once more after the end.
- R13: irq[c] is high exactly when core c has a pending pair that is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_we | input | 1 | Generate-word write strobe |
| gen_cpu | input | 3 | Number of the core that writes the generate word |
| gen_data | input | 32 | Generate word: filter [25:24], list [23:16], interrupt number in the low bits |
| ack_rd | input | NCPU | Per-core read strobe that commits the shown acknowledge word |
| ack_val | output | NCPU*32 | Per-core acknowledge word, 32 bits per core |
| irq | output | NCPU | Per-core interrupt request |
| eoi_we | input | NCPU | Per-core end write strobe |
| eoi_val | input | NCPU*32 | Per-core end word, 32 bits per core |
| clr_we | input | NCPU | Per-core active-clear write strobe |
| clr_ids | input | NCPU*NID | Per-core active-clear mask, one bit per interrupt number |

## Verification
Two functions can land in the same cycle: a generate write and a committed read on a target core. They collide when both touch the same pair. The bench provokes this by re-requesting the pair a core is reading, in the very cycle of the read strobe. The scoreboard expects the read to return the pair. It then expects the core to stay idle while the pair is active, and to receive the pair exactly once more after the end word is written.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int CPU_MAX = 8;
  localparam int SRC_W   = 3;
  localparam int IDF_W   = 10;
  localparam int SRC_LSB = 10;
  localparam int LIST_LSB = 16;
  localparam int FLT_LSB  = 24;
  localparam logic [IDF_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_NONE   = 2'd3
  } filt_e;

  // Target set over the widest possible cluster; caller trims it.
  function automatic logic [CPU_MAX-1:0] filter_targets(
    input filt_e f, input logic [CPU_MAX-1:0] list, input logic [SRC_W-1:0] writer);
    logic [CPU_MAX-1:0] me;
    me = '0;
    me[writer] = 1'b1;
    case (f)
      FLT_LIST:   return list;
      FLT_OTHERS: return ~me;
      FLT_SELF:   return me;
      default:    return '0;
    endcase
  endfunction

  // Acknowledge word layout: source in [12:10], number in [9:0].
  function automatic logic [31:0] ack_word(
    input logic valid, input logic [SRC_W-1:0] src, input logic [IDF_W-1:0] id);
    logic [31:0] w;
    w = '0;
    if (valid) begin
      w[SRC_LSB +: SRC_W] = src;
      w[IDF_W-1:0] = id;
    end else begin
      w[IDF_W-1:0] = SPURIOUS_ID;
    end
    return w;
  endfunction
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int ID_W = $clog2(NID)
) (
  input  logic             gen_we,
  input  logic [SRC_W-1:0] gen_cpu,
  input  logic [31:0]      gen_data,
  output logic [NCPU-1:0]  tgt,
  output logic [ID_W-1:0]  sgi_id
);
  filt_e              mode;
  logic [CPU_MAX-1:0] full_set;
  logic               writer_ok;
  logic               unused_bits;

  assign mode      = filt_e'(gen_data[FLT_LSB +: 2]);
  assign full_set  = filter_targets(mode, gen_data[LIST_LSB +: CPU_MAX], gen_cpu);
  assign writer_ok = int'(gen_cpu) < NCPU;
  assign tgt       = (gen_we && writer_ok) ? full_set[NCPU-1:0] : '0;
  assign sgi_id    = gen_data[ID_W-1:0];
  assign unused_bits = ^{gen_data[31:FLT_LSB+2], gen_data[LIST_LSB-1:ID_W]};
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick #(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int NPAIR = NCPU * NID,
  localparam int ID_W  = $clog2(NID),
  localparam int SW    = sgi_pkg::SRC_W
) (
  input  logic [NPAIR-1:0] ready,
  output logic             found,
  output logic [ID_W-1:0]  id,
  output logic [SW-1:0]    src
);
  // Pairs are laid out number-major, so the lowest index is the winner.
  always_comb begin
    found = 1'b0;
    id    = '0;
    src   = '0;
    for (int k = NPAIR - 1; k >= 0; k--) begin
      if (ready[k]) begin
        found = 1'b1;
        id    = ID_W'(k / NCPU);
        src   = SW'(k % NCPU);
      end
    end
  end
endmodule

// File: rtl/sgi_cpu_bank.sv
module sgi_cpu_bank
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NID  = 16,
  localparam int NPAIR  = NCPU * NID,
  localparam int ID_W   = $clog2(NID),
  localparam int PAIR_W = $clog2(NPAIR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] set_vec,
  input  logic             ack_rd,
  input  logic             eoi_we,
  input  logic [31:0]      eoi_val,
  input  logic             clr_we,
  input  logic [NID-1:0]   clr_ids,
  output logic [31:0]      ack_val,
  output logic             irq
);
  logic [NPAIR-1:0] pend_q, act_q, ready;
  logic [NPAIR-1:0] ack_oh, eoi_oh, clr_vec;
  logic             found;
  logic [ID_W-1:0]  win_id;
  logic [SRC_W-1:0] win_src;
  logic             ack_fire;
  logic             eoi_hit;
  logic [IDF_W-1:0] eoi_id;
  logic [SRC_W-1:0] eoi_src;

  assign ready = pend_q & ~act_q;

  sgi_pick #(.NCPU(NCPU), .NID(NID)) u_pick (
    .ready (ready),
    .found (found),
    .id    (win_id),
    .src   (win_src)
  );

  assign ack_fire = ack_rd & found;
  assign eoi_id   = eoi_val[IDF_W-1:0];
  assign eoi_src  = eoi_val[SRC_LSB +: SRC_W];
  assign eoi_hit  = eoi_we && (eoi_val[31:SRC_LSB+SRC_W] == '0)
                    && (int'(eoi_id) < NID) && (int'(eoi_src) < NCPU);

  always_comb begin
    ack_oh = '0;
    if (ack_fire) ack_oh[PAIR_W'(int'(win_id) * NCPU + int'(win_src))] = 1'b1;
  end

  always_comb begin
    eoi_oh = '0;
    if (eoi_hit) eoi_oh[PAIR_W'(int'(eoi_id) * NCPU + int'(eoi_src))] = 1'b1;
  end

  for (genvar n = 0; n < NID; n++) begin : g_clr
    assign clr_vec[n*NCPU +: NCPU] = {NCPU{clr_we & clr_ids[n]}};
  end

  // A fresh request wins over the read that clears the same pair.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_oh) | set_vec;
      act_q  <= (act_q & ~eoi_oh & ~clr_vec) | ack_oh;
    end
  end

  assign ack_val = ack_word(found, win_src, IDF_W'(win_id));
  assign irq     = found;
endmodule

// File: rtl/sgi_unit.sv
module sgi_unit
  import sgi_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NID  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gen_we,
  input  logic [2:0]           gen_cpu,
  input  logic [31:0]          gen_data,
  input  logic [NCPU-1:0]      ack_rd,
  output logic [NCPU*32-1:0]   ack_val,
  output logic [NCPU-1:0]      irq,
  input  logic [NCPU-1:0]      eoi_we,
  input  logic [NCPU*32-1:0]   eoi_val,
  input  logic [NCPU-1:0]      clr_we,
  input  logic [NCPU*NID-1:0]  clr_ids
);
  localparam int NPAIR  = NCPU * NID;
  localparam int ID_W   = $clog2(NID);
  localparam int PAIR_W = $clog2(NPAIR);

  logic [NCPU-1:0]  gen_tgt;
  logic [ID_W-1:0]  gen_id;
  logic [NPAIR-1:0] set_onehot;

  sgi_target_decode #(.NCPU(NCPU), .NID(NID)) u_dec (
    .gen_we   (gen_we),
    .gen_cpu  (gen_cpu),
    .gen_data (gen_data),
    .tgt      (gen_tgt),
    .sgi_id   (gen_id)
  );

  always_comb begin
    set_onehot = '0;
    if (int'(gen_cpu) < NCPU)
      set_onehot[PAIR_W'(int'(gen_id) * NCPU + int'(gen_cpu))] = 1'b1;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    sgi_cpu_bank #(.NCPU(NCPU), .NID(NID)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (gen_tgt[c] ? set_onehot : '0),
      .ack_rd  (ack_rd[c]),
      .eoi_we  (eoi_we[c]),
      .eoi_val (eoi_val[c*32 +: 32]),
      .clr_we  (clr_we[c]),
      .clr_ids (clr_ids[c*NID +: NID]),
      .ack_val (ack_val[c*32 +: 32]),
      .irq     (irq[c])
    );
  end
endmodule

// File: rtl/sgi_unit_chk.sv
module sgi_unit_chk #(
  parameter int NCPU = 4,
  parameter int NID  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gen_we,
  input logic [2:0]          gen_cpu,
  input logic [31:0]         gen_data,
  input logic [NCPU-1:0]     ack_rd,
  input logic [NCPU*32-1:0]  ack_val,
  input logic [NCPU-1:0]     irq,
  input logic [NCPU-1:0]     eoi_we,
  input logic [NCPU-1:0]     clr_we,
  input logic [NCPU-1:0]     gen_tgt
);
  logic [1:0] mode;
  logic       wr_ok;
  assign mode  = gen_data[25:24];
  assign wr_ok = int'(gen_cpu) < NCPU;

  // R5
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && mode == 2'd2 && wr_ok) |-> (gen_tgt == (NCPU'(1) << gen_cpu)));

  // R4
  others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && mode == 2'd1 && wr_ok) |->
      (((gen_tgt >> gen_cpu) & NCPU'(1)) == '0 && $countones(gen_tgt) == NCPU - 1));

  // R6
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_we && mode == 2'd3) |-> (gen_tgt == '0));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R1
    idle_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq[c] |-> (ack_val[c*32 +: 32] == 32'h0000_03FF));

    // R2
    ack_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (ack_val[c*32+13 +: 19] == '0 && int'(ack_val[c*32+10 +: 3]) < NCPU
                  && int'(ack_val[c*32 +: 10]) < NID));

    // R8
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd[c] && irq[c] && !gen_we) |=> (ack_val[c*32 +: 32] != $past(ack_val[c*32 +: 32])));

    // R7
    spurious_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd[c] && !irq[c] && !gen_we && !eoi_we[c] && !clr_we[c]) |=> !irq[c]);
  end

  logic unused_chk;
  assign unused_chk = ^{gen_data[31:26], gen_data[23:0]};
endmodule

bind sgi_unit sgi_unit_chk #(.NCPU(NCPU), .NID(NID)) u_chk (.*);

// File: tb/sgi_unit_bench.sv
`timescale 1ns/1ps
module sgi_unit_bench;
  localparam int NCPU = 4;
  localparam int NID  = 16;
  localparam logic [31:0] SPUR = 32'h0000_03FF;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                gen_we = 1'b0;
  logic [2:0]          gen_cpu = '0;
  logic [31:0]         gen_data = '0;
  logic [NCPU-1:0]     ack_rd = '0;
  logic [NCPU*32-1:0]  ack_val;
  logic [NCPU-1:0]     irq;
  logic [NCPU-1:0]     eoi_we = '0;
  logic [NCPU*32-1:0]  eoi_val = '0;
  logic [NCPU-1:0]     clr_we = '0;
  logic [NCPU*NID-1:0] clr_ids = '0;

  always #2 clk = ~clk;

  sgi_unit #(.NCPU(NCPU), .NID(NID)) u_sgi_unit (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit m_pend [NCPU][NID][NCPU];
  bit m_act  [NCPU][NID][NCPU];

  int          q_cpu [$];
  logic [31:0] q_val [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scan pairs by source within number, independent of the RTL layout.
  function automatic logic [31:0] m_expect(input int c);
    for (int id = 0; id < NID; id++)
      for (int s = 0; s < NCPU; s++)
        if (m_pend[c][id][s] && !m_act[c][id][s])
          return (32'(s) << 10) | 32'(id);
    return SPUR;
  endfunction

  function automatic logic [NCPU-1:0] m_irq();
    logic [NCPU-1:0] r;
    for (int c = 0; c < NCPU; c++) r[c] = (m_expect(c) != SPUR);
    return r;
  endfunction

  function automatic logic [31:0] mkgen(input int mode, input logic [7:0] list, input int id);
    return (32'(mode) << 24) | (32'(list) << 16) | 32'(id);
  endfunction

  task automatic gen(input int cpu, input logic [31:0] d);
    gen_we = 1'b1; gen_cpu = 3'(cpu); gen_data = d;
  endtask
  task automatic ack(input int c);
    ack_rd[c] = 1'b1;
  endtask
  task automatic eoi(input int c, input logic [31:0] v);
    eoi_we[c] = 1'b1; eoi_val[c*32 +: 32] = v;
  endtask
  task automatic clr(input int c, input logic [NID-1:0] m);
    clr_we[c] = 1'b1; clr_ids[c*NID +: NID] = m;
  endtask

  // Driver: push expected reads, advance the model, commit one edge.
  task automatic step(input string tag);
    logic [31:0] ev;
    int wid [NCPU];
    int wsrc [NCPU];
    for (int c = 0; c < NCPU; c++) begin
      wid[c] = -1; wsrc[c] = 0;
      if (ack_rd[c]) begin
        ev = m_expect(c);
        q_cpu.push_back(c); q_val.push_back(ev); q_tag.push_back(tag);
        if (ev != SPUR) begin wid[c] = int'(ev[9:0]); wsrc[c] = int'(ev[12:10]); end
      end
    end
    for (int c = 0; c < NCPU; c++) begin
      logic [31:0] v;
      v = eoi_val[c*32 +: 32];
      if (eoi_we[c] && v[31:13] == 0 && v[9:0] < NID && v[12:10] < NCPU)
        m_act[c][v[9:0]][v[12:10]] = 1'b0;
      if (clr_we[c])
        for (int id = 0; id < NID; id++)
          if (clr_ids[c*NID + id])
            for (int s = 0; s < NCPU; s++) m_act[c][id][s] = 1'b0;
      if (wid[c] >= 0) begin
        m_pend[c][wid[c]][wsrc[c]] = 1'b0;
        m_act[c][wid[c]][wsrc[c]]  = 1'b1;
      end
    end
    if (gen_we && gen_cpu < NCPU) begin
      for (int c = 0; c < NCPU; c++) begin
        bit hit;
        case (gen_data[25:24])
          2'd0: hit = gen_data[16 + c];
          2'd1: hit = (c != int'(gen_cpu));
          2'd2: hit = (c == int'(gen_cpu));
          default: hit = 1'b0;
        endcase
        if (hit) m_pend[c][gen_data[3:0]][gen_cpu] = 1'b1;
      end
    end
    @(posedge clk); #1;
    gen_we = 1'b0; gen_data = '0; gen_cpu = '0;
    ack_rd = '0; eoi_we = '0; eoi_val = '0; clr_we = '0; clr_ids = '0;
  endtask

  // Monitor: compare committed reads against the scoreboard.
  always @(negedge clk) begin
    for (int c = 0; c < NCPU; c++) begin
      if (ack_rd[c]) begin
        if (q_cpu.size() == 0) begin
          chk(1'b0, "scoreboard-empty", ack_val[c*32 +: 32], 32'hX);
        end else begin
          int qc;
          logic [31:0] qv;
          string qt;
          qc = q_cpu.pop_front(); qv = q_val.pop_front(); qt = q_tag.pop_front();
          chk(qc == c && ack_val[c*32 +: 32] === qv, qt, ack_val[c*32 +: 32], qv);
        end
      end
    end
  end

  task automatic chk_irq(input string req, input logic [NCPU-1:0] exp);
    chk(irq === exp && irq === m_irq(), req, 32'(irq), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    chk_irq("R1", 4'b0000);
    for (int c = 0; c < NCPU; c++) chk(ack_val[c*32 +: 32] === SPUR, "R1", ack_val[c*32 +: 32], SPUR);

    // R5: self only from core 1, number 1
    gen(1, mkgen(2, 8'h00, 1)); step("R5");
    chk_irq("R5", 4'b0010);
    ack(1); step("R2 R5 read 0x401");
    chk_irq("R8", 4'b0000);
    ack(1); step("R8 active not offered");
    eoi(1, 32'h0000_0401); step("R10");

    // R4: all but writer, number 5 from core 1
    gen(1, mkgen(1, 8'h00, 5)); step("R4");
    chk_irq("R4", 4'b1101);
    ack(0); ack(2); ack(3); step("R4 read 0x405");
    ack(1); step("R7 spurious read");
    chk_irq("R7", 4'b0000);
    for (int c = 0; c < NCPU; c++) chk(ack_val[c*32 +: 32] === SPUR, "R7", ack_val[c*32 +: 32], SPUR);

    // R3: list 0xF5 from core 2: cores 0 and 2, upper list bits ignored
    gen(2, mkgen(0, 8'hF5, 3)); step("R3");
    chk_irq("R3", 4'b0101);
    ack(2); step("R3 core 2 read");

    // R9: several pairs pending on core 0
    gen(3, mkgen(0, 8'h01, 7)); step("R9");
    gen(2, mkgen(0, 8'h01, 7)); step("R9");
    gen(1, mkgen(0, 8'h01, 2)); step("R9");
    ack(0); step("R9 first 0x402");
    ack(0); step("R9 second 0x803");
    ack(0); step("R9 third 0x807");
    ack(0); step("R9 fourth 0xC07");
    ack(0); step("R9 drained");

    // R8 / R11: re-request while active is held; active-clear frees all sources
    gen(2, mkgen(0, 8'h01, 7)); step("R8");
    chk_irq("R8 held", 4'b0000);
    clr(0, 16'h0080); step("R11");
    chk_irq("R11", 4'b0001);
    ack(0); step("R11 read 0x807");
    gen(3, mkgen(0, 8'h01, 7)); step("R11");
    chk_irq("R11 other source freed", 4'b0001);
    ack(0); step("R11 read 0xC07");

    // R10: wrong end word ignored, exact word ends
    eoi(0, 32'h0000_0403); step("R10");
    eoi(0, 32'h0001_0803); step("R10");
    gen(2, mkgen(0, 8'h01, 3)); step("R10");
    chk_irq("R10 not ended", 4'b0000);
    eoi(0, 32'h0000_0803); step("R10");
    chk_irq("R10 ended", 4'b0001);
    ack(0); step("R10 read 0x803");

    // R12: request and read of the same pair in one cycle
    gen(0, mkgen(0, 8'h08, 9)); step("R12");
    gen(0, mkgen(0, 8'h08, 9)); ack(3); step("R12 read 0x009");
    chk_irq("R12 held", 4'b0000);
    eoi(3, 32'h0000_0009); step("R12");
    chk_irq("R12 redelivered", 4'b1000);
    ack(3); step("R12 second read 0x009");
    ack(3); step("R12 exactly once");

    // R6: reserved filter raises nothing
    gen(0, mkgen(3, 8'h0F, 4)); step("R6");
    chk_irq("R6 R13", 4'b0000);
    for (int c = 0; c < NCPU; c++) chk(ack_val[c*32 +: 32] === SPUR, "R6", ack_val[c*32 +: 32], SPUR);

    repeat (2) @(posedge clk);
    chk(q_cpu.size() == 0, "scoreboard-drain", 32'(q_cpu.size()), 32'(0));
    finish_run();
  end
endmodule